// File: doc/BRIEF.md
# Repetitive Pattern Receive Synchronizer

This block is the receive half of a bit-error-rate tester that runs with a short repeating test word. It takes a serial stream qualified by a bit enable and a programmed period of 1 to 32 bits. It watches for the stream to repeat itself at that period. When it has seen enough consecutive repeats, it declares lock. It never checks what the repeating content is. A constant stream, or one whose true period divides the programmed one, locks in the same way as the intended word.

At lock the block freezes the last period's worth of bits into a readable pattern word. Software must compare that word with the word it meant to send. Two flags mark a captured word of all zeros or all ones. While locked, each new bit is checked against the frozen word, and every disagreement adds one to a saturating error counter. A latch pulse moves the count into a holding register and restarts the counter. A burst of errors drops lock, and the block then searches again.

Top module: `psync_rx`

## Requirements
- R1: A clock edge with `bit_en` low changes none of `locked`, `rx_pattern` or `err_count`, whatever `bit_in` carries.
- R2: During search, each enabled bit is compared with the bit received L enabled bits earlier, where L is the programmed period. The history reads as zero after reset. `locked` rises at the edge that samples the 2L-th consecutive match. Any mismatch sets the run back to zero.
- R3: Content is never judged. Streams of all zeros, all ones, or with a period that divides L all lock, at every L from 1 to 32.
- R4: A stream whose period does not divide L, such as the 3-bit word 110 with L = 8, never locks.
- R5: At lock, `rx_pattern[L-1:0]` holds the last L bits received. Bit L-1 is the oldest and bit 0 the newest, and all bits above L-1 are zero. The word does not change while `locked` stays high.
- R6: `all_zero` and `all_one` are high only while locked, when the captured L bits are all 0 or all 1 respectively.
- R7: While locked, the expected bit cycles through the captured word, starting at bit L-1 and moving down toward bit 0. Each enabled bit that differs adds one to `err_count` at the edge that samples it. A clean periodic stream adds nothing.
- R8: `err_count` saturates at 2^CNT_W-1 and does not wrap.
- R9: At an edge with `err_latch` high, `err_hold` takes the current `err_count`. `err_count` restarts at 0, or at 1 if that edge also samples an error.
- R10: While locked, a sixth error within the last 64 enabled bits drops `locked` at that edge. `sync_lost` pulses high for one cycle, and search restarts with an empty run. Five errors in any 64 bits keep lock.
- R11: After reset, `locked`, `sync_lost`, `all_zero`, `all_one`, `rx_pattern`, `err_count` and `err_hold` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Qualifies `bit_in` on this edge |
| bit_in | input | 1 | Received serial bit |
| pat_len | input | 6 | Programmed period L; 0 acts as 1, values above 32 act as 32 |
| err_latch | input | 1 | One-cycle pulse: copy count to hold and restart it |
| locked | output | 1 | Synchronized |
| sync_lost | output | 1 | One-cycle pulse when lock is dropped |
| rx_pattern | output | 32 | Captured pattern word |
| all_zero | output | 1 | Captured word is all zeros (locked only) |
| all_one | output | 1 | Captured word is all ones (locked only) |
| err_count | output | 24 | Live saturating bit-error count |
| err_hold | output | 24 | Count copied by the last latch pulse |

## Verification
Some rules are checked on every cycle. An idle edge leaves lock, word and count alone. The captured word stays fixed while locked, and the content flags never show without lock. The count only grows except at a latch, sticks at its maximum, and is copied on a latch. The lock-drop pulse follows a locked cycle. Only the bench scenarios can show the exact edge at which lock rises for each stream, that wrong-content and divisor-period streams lock, that a non-divisor period never locks, the five-versus-six error threshold in a 64-bit window, and the cycle of relock after a loss.

// File: rtl/psync_pkg.sv
// Shared types for the repetitive pattern receive synchronizer.
// Assumes nothing beyond the defaults of its users.
package psync_pkg;
    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } sync_state_e;
endpackage

// File: rtl/psync_history.sv
// Bit history shift register. Supplies the bit received exactly L enabled
// bits ago and the last L bits including the current one, masked to L.
// Assumes MAX_LEN >= 2 and len_m1 < MAX_LEN.
module psync_history #(
    parameter int MAX_LEN = 32,
    localparam int IDX_W  = $clog2(MAX_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               bit_in,
    input  logic [IDX_W-1:0]   len_m1,
    input  logic [MAX_LEN-1:0] len_mask,
    output logic               delayed_bit,
    output logic [MAX_LEN-1:0] window_word
);
    logic [MAX_LEN-1:0] hist_q;

    // Shift in each enabled bit; index 0 is the newest stored bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (bit_en) begin
            hist_q <= {hist_q[MAX_LEN-2:0], bit_in};
        end
    end

    // Tap L bits back and form the last-L-bits word.
    always_comb begin
        delayed_bit = hist_q[len_m1];
        window_word = {hist_q[MAX_LEN-2:0], bit_in} & len_mask;
    end
endmodule

// File: rtl/psync_search.sv
// Run counter for the period search. Counts consecutive bits that equal the
// bit one period earlier and signals a hit on the 2L-th match.
// Assumes len_m1 is the period minus one.
module psync_search #(
    parameter int MAX_LEN = 32,
    localparam int IDX_W  = $clog2(MAX_LEN),
    localparam int RUN_W  = $clog2(2 * MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             searching,
    input  logic             bit_en,
    input  logic             match,
    input  logic [IDX_W-1:0] len_m1,
    output logic             hit
);
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_inc;
    logic [RUN_W-1:0] target;

    // Target run length is twice the period.
    always_comb begin
        target  = (RUN_W'(len_m1) + RUN_W'(1)) << 1;
        run_inc = run_q + RUN_W'(1);
        hit     = searching && bit_en && match && (run_inc == target);
    end

    // Advance on matches, restart on a mismatch, a hit or outside search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!searching || hit) begin
            run_q <= '0;
        end else if (bit_en) begin
            run_q <= match ? run_inc : '0;
        end
    end
endmodule

// File: rtl/psync_err_window.sv
// Sliding window of per-bit error flags over the last WIN_LEN locked bits.
// Raises trip when the count including the current bit reaches ERR_LIMIT.
// Assumes clear is held for every cycle spent outside lock.
module psync_err_window #(
    parameter int WIN_LEN   = 64,
    parameter int ERR_LIMIT = 6,
    localparam int SUM_W    = $clog2(WIN_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic err,
    output logic trip
);
    logic [WIN_LEN-1:0] flags_q;
    logic [SUM_W-1:0]   sum_q;
    logic [SUM_W-1:0]   sum_next;

    // Running sum: add the new flag, drop the one leaving the window.
    always_comb begin
        sum_next = sum_q + SUM_W'(err) - SUM_W'(flags_q[WIN_LEN-1]);
        trip     = step && !clear && (sum_next >= SUM_W'(ERR_LIMIT));
    end

    // Hold the flag history and its population count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            flags_q <= '0;
            sum_q   <= '0;
        end else if (step) begin
            flags_q <= {flags_q[WIN_LEN-2:0], err};
            sum_q   <= sum_next;
        end
    end
endmodule

// File: rtl/psync_err_counter.sv
// Saturating bit-error counter with a latch that copies the count into a
// holding register and restarts the count in the same edge.
// Assumes inc is at most one per cycle.
module psync_err_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             latch,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] hold
);
    // Count errors, stick at all ones, and hand over on a latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            hold  <= '0;
        end else if (latch) begin
            hold  <= count;
            count <= CNT_W'(inc);
        end else if (inc && (count != '1)) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/psync_rx.sv
// Repetitive pattern receive synchronizer. Searches for repetition at the
// programmed period, captures the pattern at lock, counts deviations and
// drops lock on an error burst. Assumes pat_len is static while locked.
module psync_rx
    import psync_pkg::*;
#(
    parameter int MAX_LEN   = 32,
    parameter int LEN_W     = 6,
    parameter int CNT_W     = 24,
    parameter int WIN_LEN   = 64,
    parameter int ERR_LIMIT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               bit_in,
    input  logic [LEN_W-1:0]   pat_len,
    input  logic               err_latch,
    output logic               locked,
    output logic               sync_lost,
    output logic [MAX_LEN-1:0] rx_pattern,
    output logic               all_zero,
    output logic               all_one,
    output logic [CNT_W-1:0]   err_count,
    output logic [CNT_W-1:0]   err_hold
);
    localparam int IDX_W = $clog2(MAX_LEN);

    sync_state_e        state_q;
    logic [IDX_W-1:0]   len_m1;
    logic [MAX_LEN-1:0] len_mask;
    logic [MAX_LEN-1:0] cap_q;
    logic [MAX_LEN-1:0] ref_q;
    logic [MAX_LEN-1:0] ref_rot;
    logic [MAX_LEN-1:0] window_word;
    logic               delayed_bit;
    logic               hit;
    logic               trip;
    logic               los_q;
    logic               searching;
    logic               lock_step;
    logic               bit_err;

    // Clamp the programmed period into 1..MAX_LEN and keep it minus one.
    always_comb begin
        if (pat_len == '0) begin
            len_m1 = '0;
        end else if (pat_len > LEN_W'(MAX_LEN)) begin
            len_m1 = IDX_W'(MAX_LEN - 1);
        end else begin
            len_m1 = IDX_W'(pat_len - LEN_W'(1));
        end
    end

    // One mask bit per position below the period.
    for (genvar gi = 0; gi < MAX_LEN; gi++) begin : g_mask
        assign len_mask[gi] = (IDX_W'(gi) <= len_m1);
    end

    // Rotate the reference word by one within the period.
    for (genvar gr = 0; gr < MAX_LEN; gr++) begin : g_rot
        if (gr == 0) begin : g_head
            assign ref_rot[gr] = ref_q[len_m1];
        end else begin : g_body
            assign ref_rot[gr] = ref_q[gr-1] & len_mask[gr];
        end
    end

    // Mode qualifiers and per-bit error against the captured pattern.
    always_comb begin
        searching = (state_q == ST_SEARCH);
        lock_step = (state_q == ST_LOCKED) && bit_en;
        bit_err   = bit_in ^ ref_q[len_m1];
    end

    psync_history #(
        .MAX_LEN(MAX_LEN)
    ) i_history (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .bit_in     (bit_in),
        .len_m1     (len_m1),
        .len_mask   (len_mask),
        .delayed_bit(delayed_bit),
        .window_word(window_word)
    );

    psync_search #(
        .MAX_LEN(MAX_LEN)
    ) i_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .searching(searching),
        .bit_en   (bit_en),
        .match    (bit_in == delayed_bit),
        .len_m1   (len_m1),
        .hit      (hit)
    );

    psync_err_window #(
        .WIN_LEN  (WIN_LEN),
        .ERR_LIMIT(ERR_LIMIT)
    ) i_window (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(searching),
        .step (lock_step),
        .err  (bit_err),
        .trip (trip)
    );

    psync_err_counter #(
        .CNT_W(CNT_W)
    ) i_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (lock_step && bit_err),
        .latch(err_latch),
        .count(err_count),
        .hold (err_hold)
    );

    // Search/lock state, pattern capture, reference rotation, loss pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
            cap_q   <= '0;
            ref_q   <= '0;
            los_q   <= 1'b0;
        end else begin
            los_q <= 1'b0;
            case (state_q)
                ST_SEARCH: begin
                    if (hit) begin
                        state_q <= ST_LOCKED;
                        cap_q   <= window_word;
                        ref_q   <= window_word;
                    end
                end
                default: begin
                    if (bit_en) begin
                        ref_q <= ref_rot;
                        if (trip) begin
                            state_q <= ST_SEARCH;
                            los_q   <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Status outputs derived from the state and the captured word.
    always_comb begin
        locked     = (state_q == ST_LOCKED);
        sync_lost  = los_q;
        rx_pattern = cap_q;
        all_zero   = locked && ((cap_q & len_mask) == '0);
        all_one    = locked && ((cap_q & len_mask) == len_mask);
    end
endmodule

// Property checker for psync_rx, bound to every instance.
module psync_rx_chk #(
    parameter int MAX_LEN = 32,
    parameter int CNT_W   = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bit_en,
    input logic               err_latch,
    input logic               locked,
    input logic               sync_lost,
    input logic [MAX_LEN-1:0] rx_pattern,
    input logic               all_zero,
    input logic               all_one,
    input logic [CNT_W-1:0]   err_count,
    input logic [CNT_W-1:0]   err_hold
);
    AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !err_latch) |=> ($stable(err_count) && $stable(locked) && $stable(rx_pattern))); // R1

    AST_PATTERN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (!locked || $stable(rx_pattern))); // R5

    AST_FLAGS_NEED_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (all_zero || all_one) |-> locked); // R6

    AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !err_latch |=> (err_count >= $past(err_count))); // R7

    AST_CNT_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !err_latch) |=> $stable(err_count)); // R7

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((&err_count) && !err_latch) |=> (&err_count)); // R8

    AST_LATCH_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        err_latch |=> (err_hold == $past(err_count))); // R9

    AST_LOST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |-> (!locked && $past(locked))); // R10
endmodule

bind psync_rx psync_rx_chk #(
    .MAX_LEN(MAX_LEN),
    .CNT_W  (CNT_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .err_latch (err_latch),
    .locked    (locked),
    .sync_lost (sync_lost),
    .rx_pattern(rx_pattern),
    .all_zero  (all_zero),
    .all_one   (all_one),
    .err_count (err_count),
    .err_hold  (err_hold)
);

// File: tb/test_psync_rx.sv
module test_psync_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic        err_latch = 1'b0;
    logic [5:0]  pat_len = 6'd8;
    logic        locked, sync_lost, all_zero, all_one;
    logic [31:0] rx_pattern;
    logic [23:0] err_count, err_hold;
    logic        s_locked, s_lost, s_zero, s_one;
    logic [31:0] s_pattern;
    logic [3:0]  s_count, s_hold;

    int          checks = 0;
    int          fails = 0;
    int          t_idx = 0;
    int          cur_per = 8;
    logic [31:0] cur_word = 32'hB8;
    bit          done = 1'b0;

    typedef struct packed {
        logic [5:0]  len;
        logic [5:0]  per;
        logic [31:0] word;
        logic        exp_zero;
        logic        exp_one;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{6'd8,  6'd8,  32'h0000_00B8, 1'b0, 1'b0},
        '{6'd8,  6'd1,  32'h0000_0000, 1'b1, 1'b0},
        '{6'd8,  6'd1,  32'h0000_0001, 1'b0, 1'b1},
        '{6'd8,  6'd8,  32'h0000_00F0, 1'b0, 1'b0},
        '{6'd8,  6'd2,  32'h0000_0002, 1'b0, 1'b0},
        '{6'd32, 6'd32, 32'hDEAD_BEEF, 1'b0, 1'b0},
        '{6'd1,  6'd1,  32'h0000_0001, 1'b0, 1'b1},
        '{6'd6,  6'd3,  32'h0000_0006, 1'b0, 1'b0},
        '{6'd5,  6'd5,  32'h0000_0016, 1'b0, 1'b0}
    };

    always #10 clk = ~clk;

    psync_rx i_psync_rx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .pat_len(pat_len), .err_latch(err_latch), .locked(locked),
        .sync_lost(sync_lost), .rx_pattern(rx_pattern), .all_zero(all_zero),
        .all_one(all_one), .err_count(err_count), .err_hold(err_hold)
    );

    psync_rx #(.CNT_W(4)) i_psync_rx_sat (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .pat_len(pat_len), .err_latch(err_latch), .locked(s_locked),
        .sync_lost(s_lost), .rx_pattern(s_pattern), .all_zero(s_zero),
        .all_one(s_one), .err_count(s_count), .err_hold(s_hold)
    );

    function automatic logic stream_bit(input int t);
        return cur_word[cur_per - 1 - (t % cur_per)];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; err_latch = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_idx = 0;
    endtask

    task automatic send(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        bit_en = 1'b0;
        @(posedge clk);
        #1;
    endtask

    // Send n stream bits; flip the last bit of every flip_per group.
    task automatic send_pat(input int n, input int flip_per);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = stream_bit(t_idx);
            if (flip_per > 0 && (i % flip_per) == flip_per - 1) b = ~b;
            send(b);
            t_idx++;
        end
    endtask

    function automatic logic [31:0] last_word(input int len, input int upto);
        logic [31:0] w = '0;
        for (int k = 0; k < len; k++) w[len - 1 - k] = stream_bit(upto - len + k);
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        do_reset();
        @(posedge clk); #1;
        // R11: reset state
        check("R11 locked", 64'(locked), 64'd0);
        check("R11 sync_lost", 64'(sync_lost), 64'd0);
        check("R11 flags", 64'({all_zero, all_one}), 64'd0);
        check("R11 rx_pattern", 64'(rx_pattern), 64'd0);
        check("R11 counts", 64'({err_count, err_hold}), 64'd0);

        // Table walk: lock edge, captured word, flags, clean run (R2 R3 R5 R6 R7)
        for (int v = 0; v < 9; v++) begin
            int len, z, n;
            pat_len  = VECS[v].len;
            cur_per  = int'(VECS[v].per);
            cur_word = VECS[v].word;
            do_reset();
            len = int'(VECS[v].len);
            z = 0;
            for (int k = len - 1; k >= 0; k--) begin
                if (stream_bit(k) != 1'b0) break;
                z++;
            end
            n = 3 * len - z;
            send_pat(n - 1, 0);
            check("R2 not yet locked", 64'(locked), 64'd0);
            send_pat(1, 0);
            check("R2 R3 locked on 2L-th match", 64'(locked), 64'd1);
            check("R5 captured word", 64'(rx_pattern), 64'(last_word(len, n)));
            check("R6 all_zero", 64'(all_zero), 64'(VECS[v].exp_zero));
            check("R6 all_one", 64'(all_one), 64'(VECS[v].exp_one));
            send_pat(2 * len, 0);
            check("R7 clean stream no errors", 64'(err_count), 64'd0);
            check("R5 word held while locked", 64'(rx_pattern), 64'(last_word(len, n)));
        end

        // R2: mismatch restarts the run, L=4
        pat_len = 6'd4; cur_per = 1; cur_word = 32'h0;
        do_reset();
        repeat (7) send(1'b0);
        send(1'b1);
        repeat (11) send(1'b0);
        check("R2 run restarted", 64'(locked), 64'd0);
        send(1'b0);
        check("R2 lock after restart", 64'(locked), 64'd1);
        check("R6 zero word flag", 64'({all_zero, all_one}), 64'b10);

        // R4: period 3 with L=8 never locks
        pat_len = 6'd8; cur_per = 3; cur_word = 32'h6;
        do_reset();
        begin
            int seen = 0;
            for (int i = 0; i < 200; i++) begin
                send_pat(1, 0);
                if (locked) seen++;
            end
            check("R4 non-divisor never locks", 64'(seen), 64'd0);
        end

        // Error counting, idle, latch, saturation, loss, relock (R1 R7 R8 R9 R10)
        pat_len = 6'd8; cur_per = 8; cur_word = 32'hB8;
        do_reset();
        send_pat(21, 0);
        check("R2 lock for error test", 64'(locked), 64'd1);
        send_pat(39, 13);
        check("R7 three errors", 64'(err_count), 64'd3);
        held = rx_pattern;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = i[0];
            @(posedge clk);
        end
        #1;
        check("R1 idle count", 64'(err_count), 64'd3);
        check("R1 idle lock", 64'(locked), 64'd1);
        check("R1 idle word", 64'(rx_pattern), 64'(held));
        @(negedge clk);
        err_latch = 1'b1;
        @(posedge clk); #1;
        check("R9 hold copy", 64'(err_hold), 64'd3);
        check("R9 count restart", 64'(err_count), 64'd0);
        @(negedge clk);
        err_latch = 1'b0;
        send_pat(13 * 17, 13);
        check("R7 seventeen errors", 64'(err_count), 64'd17);
        check("R8 narrow counter saturates", 64'(s_count), 64'd15);
        check("R10 five per window keeps lock", 64'(locked), 64'd1);
        send_pat(64, 0);
        send_pat(60, 12);
        check("R10 five errors keep lock", 64'(locked), 64'd1);
        send_pat(12, 12);
        check("R10 sixth error drops lock", 64'(locked), 64'd0);
        check("R10 loss pulse", 64'(sync_lost), 64'd1);
        check("R7 error on losing bit counted", 64'(err_count), 64'd23);
        idle();
        check("R10 loss pulse one cycle", 64'(sync_lost), 64'd0);
        send_pat(23, 0);
        check("R10 search restarted", 64'(locked), 64'd0);
        send_pat(1, 0);
        check("R10 relock", 64'(locked), 64'd1);
        check("R5 relock word", 64'(rx_pattern), 64'(last_word(8, t_idx)));

        idle();
        finish_run();
    end
endmodule